// File: doc/BRIEF.md
# Edge-Prescaled Timer Capture Unit

This unit watches one external input pin and copies a free-running timer value into a holding register when a chosen pin event occurs. A four-bit mode input selects the event. The choices are every falling edge, every rising edge, every fourth rising edge, or every sixteenth rising edge. Any other mode code turns capturing off. Each capture sets a sticky interrupt flag, and software drops that flag with a one-cycle clear strobe.

The pin is asynchronous to the clock. It passes through a two-flop synchronizer, and an edge detector follows. Rising edges feed a small counter that implements the divide-by-four and divide-by-sixteen settings. That counter returns to zero only on reset or when the mode leaves the capture range. A move from one capture setting to another leaves the count where it was, so the first capture after such a move can come early. The captured value appears as a plain output that software may read at any time, and reading it has no side effect.

Top module: `tcap_unit`

## Requirements
- R1: After reset `cap_value` is 0 and `cap_flag` is 0.
- R2: In mode 4'b0100 every falling edge of `pin_in` causes a capture, and rising edges cause none.
- R3: In mode 4'b0101 every rising edge of `pin_in` causes a capture, and falling edges cause none.
- R4: In mode 4'b0110 a capture occurs on the 4th, 8th, 12th, ... rising edge counted from entry into capture operation.
- R5: In mode 4'b0111 a capture occurs on the 16th, 32nd, ... rising edge counted from entry into capture operation.
- R6: A capture loads the `timer_val` present at the third rising clock edge after the clock edge that first samples the new pin level. `cap_flag` goes high at that same edge.
- R7: `cap_flag` stays high until `flag_clr` is pulsed. It then reads 0 after the next clock edge.
- R8: If `flag_clr` and a capture fall on the same clock edge, `cap_flag` ends up set.
- R9: A later capture overwrites `cap_value` even if the flag is still set. Between captures `cap_value` holds its value.
- R10: Modes outside 4'b0100..4'b0111, including the off code 4'b0000, never capture and reset the rising-edge prescaler count to zero.
- R11: Switching between capture modes keeps the prescaler count. After 6 rising edges in 4'b0111, a switch to 4'b0110 captures on the 2nd following rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| timer_val | input | 16 | Current value of the free-running timer |
| pin_in | input | 1 | Asynchronous external event pin |
| mode | input | 4 | Capture mode select |
| flag_clr | input | 1 | One-cycle strobe that clears the capture flag |
| cap_value | output | 16 | Most recently captured timer value |
| cap_flag | output | 1 | Sticky capture interrupt flag |

## Verification
The assertions assume that `mode` and `flag_clr` are synchronous to `clk`. They also assume that `pin_in` holds each level for at least two clock cycles, so that no edge is lost in the synchronizer. The stimulus changes every input on the falling clock edge. It holds each pin level for four or more cycles and changes the mode only while the pin is quiet, which means every edge is seen exactly once. The sweep visits all sixteen mode codes. Before each code it passes through the off code, so the bench knows the prescaler count exactly and can compute each capture point by modular arithmetic.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_FALL = 2'd1,
        EV_RISE = 2'd2
    } ev_kind_e;

    typedef enum logic [1:0] {
        DIV_1  = 2'd0,
        DIV_LO = 2'd1,
        DIV_HI = 2'd2
    } div_e;

    typedef struct packed {
        ev_kind_e kind;
        div_e     div;
    } sel_t;

    function automatic sel_t decode_mode(input logic [3:0] m);
        sel_t s;
        s.kind = EV_NONE;
        s.div  = DIV_1;
        case (m)
            4'b0100: s.kind = EV_FALL;
            4'b0101: s.kind = EV_RISE;
            4'b0110: begin s.kind = EV_RISE; s.div = DIV_LO; end
            4'b0111: begin s.kind = EV_RISE; s.div = DIV_HI; end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tcap_pin_sync.sv
module tcap_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int MSB = STAGES - 1;

    typedef struct packed {
        logic [MSB:0] sh;
        logic         last;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.sh   = {state_q.sh[MSB-1:0], pin};
        state_d.last = state_q.sh[MSB];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rise = state_q.sh[MSB] & ~state_q.last;
    assign fall = ~state_q.sh[MSB] & state_q.last;

endmodule

// File: rtl/tcap_prescale.sv
module tcap_prescale
    import tcap_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int LO_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  div_e             div,
    output logic             hit,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t state_d, state_q;
    logic   wrap_pt;

    always_comb begin
        case (div)
            DIV_LO:  wrap_pt = &state_q.cnt[LO_W-1:0];
            DIV_HI:  wrap_pt = &state_q.cnt;
            default: wrap_pt = 1'b1;
        endcase
        hit = step & wrap_pt;

        state_d = state_q;
        if (clr)       state_d.cnt = '0;
        else if (step) state_d.cnt = state_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign count = state_q.cnt;

endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
    import tcap_pkg::*;
#(
    parameter int TW      = 16,
    parameter int CNT_W   = 4,
    parameter int LO_W    = 2,
    parameter int SYNC_ST = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer_val,
    input  logic          pin_in,
    input  logic [3:0]    mode,
    input  logic          flag_clr,
    output logic [TW-1:0] cap_value,
    output logic          cap_flag
);
    typedef struct packed {
        logic          fire;
        logic [TW-1:0] value;
        logic          flag;
    } state_t;

    state_t           state_d, state_q;
    sel_t             sel;
    logic             pin_rise, pin_fall;
    logic             ps_hit;
    logic             qualified;
    logic             fire_q;
    logic [CNT_W-1:0] ps_count;

    assign sel = decode_mode(mode);

    tcap_pin_sync #(.STAGES(SYNC_ST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin_in),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    tcap_prescale #(.CNT_W(CNT_W), .LO_W(LO_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sel.kind == EV_NONE),
        .step  (pin_rise && sel.kind != EV_NONE),
        .div   (sel.div),
        .hit   (ps_hit),
        .count (ps_count)
    );

    always_comb begin
        qualified = 1'b0;
        case (sel.kind)
            EV_FALL: qualified = pin_fall;
            EV_RISE: qualified = ps_hit;
            default: qualified = 1'b0;
        endcase

        state_d      = state_q;
        state_d.fire = qualified;
        if (state_q.fire) begin
            state_d.value = timer_val;
            state_d.flag  = 1'b1;
        end else if (flag_clr) begin
            state_d.flag  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign fire_q    = state_q.fire;
    assign cap_value = state_q.value;
    assign cap_flag  = state_q.flag;

endmodule

// File: rtl/tcap_unit_chk.sv
module tcap_unit_chk #(
    parameter int TW    = 16,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TW-1:0]    timer_val,
    input logic [3:0]       mode,
    input logic             flag_clr,
    input logic [TW-1:0]    cap_value,
    input logic             cap_flag,
    input logic             fire_q,
    input logic [CNT_W-1:0] ps_count
);
    assert_capture_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> cap_value == $past(timer_val));

    assert_flag_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> cap_flag);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !flag_clr) |=> cap_flag);

    assert_flag_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !fire_q) |=> !cap_flag);

    assert_capture_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && fire_q) |=> cap_flag);

    assert_value_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_q |=> $stable(cap_value));

    assert_off_clears_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[3:2] != 2'b01) |=> ps_count == '0);

    assert_fire_needs_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> $past(mode[3:2] == 2'b01));

endmodule

bind tcap_unit tcap_unit_chk #(.TW(TW), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .timer_val (timer_val),
    .mode      (mode),
    .flag_clr  (flag_clr),
    .cap_value (cap_value),
    .cap_flag  (cap_flag),
    .fire_q    (fire_q),
    .ps_count  (ps_count)
);

// File: tb/tcap_unit_test.sv
`timescale 1ns/1ps
module tcap_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_val = 16'h1000;
    logic        pin_in = 1'b0;
    logic [3:0]  mode = 4'b0000;
    logic        flag_clr = 1'b0;
    logic [15:0] cap_value;
    logic        cap_flag;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tcap_unit uut (
        .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .pin_in(pin_in),
        .mode(mode), .flag_clr(flag_clr), .cap_value(cap_value), .cap_flag(cap_flag)
    );

    task automatic tick();
        @(negedge clk);
        timer_val = timer_val + 16'd1;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive a pin level, wait until after the capture edge; returns T+3.
    task automatic edge_to(input logic lvl, output logic [15:0] expv);
        tick();
        pin_in = lvl;
        expv = timer_val + 16'd3;
        repeat (4) tick();
    endtask

    task automatic clear_flag();
        tick(); flag_clr = 1'b1;
        tick(); flag_clr = 1'b0;
    endtask

    task automatic go_off();
        tick(); mode = 4'b0000;
        tick();
        clear_flag();
    endtask

    initial begin
        logic [15:0] ev;
        logic [15:0] held;
        bit expf;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 value", cap_value, 16'h0000);
        chk("R1 flag", {15'd0, cap_flag}, 16'd0);

        // Sweep every mode code: R2 R3 R4 R5 R6 R10
        for (int m = 0; m < 16; m++) begin
            go_off();
            tick(); mode = 4'(m);
            for (int i = 1; i <= 32; i++) begin
                edge_to(1'b1, ev);
                case (m)
                    5: expf = 1'b1;
                    6: expf = (i % 4) == 0;
                    7: expf = (i % 16) == 0;
                    default: expf = 1'b0;
                endcase
                chk(m == 5 ? "R3 rise flag" : m == 6 ? "R4 div4 flag" :
                    m == 7 ? "R5 div16 flag" : m == 4 ? "R2 no rise capture" :
                    "R10 no capture", {15'd0, cap_flag}, {15'd0, expf});
                if (expf) begin
                    chk("R6 rise value", cap_value, ev);
                    clear_flag();
                end
                edge_to(1'b0, ev);
                expf = (m == 4);
                chk(m == 4 ? "R2 fall flag" : "R3/R10 no fall capture",
                    {15'd0, cap_flag}, {15'd0, expf});
                if (expf) begin
                    chk("R6 fall value", cap_value, ev);
                    clear_flag();
                end
            end
        end

        // R7 sticky flag and clear; R9 overwrite and hold
        go_off();
        tick(); mode = 4'b0101;
        edge_to(1'b1, ev);
        held = ev;
        repeat (6) tick();
        chk("R7 flag sticky", {15'd0, cap_flag}, 16'd1);
        chk("R9 value holds", cap_value, held);
        edge_to(1'b0, ev);
        edge_to(1'b1, ev);
        chk("R9 overwrite", cap_value, ev);
        chk("R9 overwrite flag", {15'd0, cap_flag}, 16'd1);
        clear_flag();
        chk("R7 flag cleared", {15'd0, cap_flag}, 16'd0);
        chk("R9 value after clear", cap_value, ev);

        // R8 clear strobe coincides with capture edge
        edge_to(1'b0, ev);
        tick(); pin_in = 1'b1; ev = timer_val + 16'd3;
        tick(); flag_clr = 1'b1;
        tick(); flag_clr = 1'b0;
        tick(); flag_clr = 1'b1;
        tick(); flag_clr = 1'b0;
        chk("R8 capture beats clear", {15'd0, cap_flag}, 16'd1);
        chk("R8 value", cap_value, ev);
        // clear strobe in cycle after the capture cycle: no capture then, flag drops
        edge_to(1'b0, ev);
        clear_flag();
        chk("R8 later clear", {15'd0, cap_flag}, 16'd0);

        // R11: 6 edges in div16, switch to div4, capture on 2nd edge
        go_off();
        tick(); mode = 4'b0111;
        for (int i = 0; i < 6; i++) begin
            edge_to(1'b1, ev);
            edge_to(1'b0, ev);
        end
        chk("R11 no early capture", {15'd0, cap_flag}, 16'd0);
        tick(); mode = 4'b0110;
        edge_to(1'b1, ev);
        chk("R11 first edge after switch", {15'd0, cap_flag}, 16'd0);
        edge_to(1'b0, ev);
        edge_to(1'b1, ev);
        chk("R11 early capture", {15'd0, cap_flag}, 16'd1);
        chk("R11 value", cap_value, ev);
        clear_flag();

        // R10: non-capture mode resets prescaler count
        go_off();
        tick(); mode = 4'b0111;
        for (int i = 0; i < 5; i++) begin
            edge_to(1'b1, ev);
            edge_to(1'b0, ev);
        end
        tick(); mode = 4'b1000;
        tick(); mode = 4'b0111;
        for (int i = 1; i <= 16; i++) begin
            edge_to(1'b1, ev);
            chk("R10 count restarted", {15'd0, cap_flag}, {15'd0, i == 16});
            edge_to(1'b0, held);
        end
        chk("R10 value after restart", cap_value, ev);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule